// File: doc/BRIEF.md
# Stream Frame Timing Monitor

This block watches a transmit stream and a receive stream that run on one clock. For each direction it measures one framed transfer. It counts the clock cycles from the frame-start marker to the frame-end marker, counting both marker cycles. It also counts the cycles inside that window in which a data beat was valid. The block never looks at the data itself.

Software uses a small register port. It writes the control register to arm one or both directions. It then polls the status register until the done bit of each armed direction is set, and reads the four result registers. Software turns those counts into a rate. Each direction is armed, measured and finished on its own, so the two directions may overlap in time or not.

The result counters are `CNT_W` bits wide and stop at all-ones instead of wrapping. A clear command returns both directions to rest in a single cycle.

Top module: `sfm_top`

## Requirements
- R1: After reset, every register reads zero: control, status and the four counts.
- R2: Writing byte offset 0x00 with bit0 set arms the transmit direction, and with bit1 set arms the receive direction. Reading offset 0x00 returns bit0 and bit1 as 1 while that direction is armed or measuring. Bit2 always reads 0.
- R3: The cycle count (TX at 0x08, RX at 0x0C) equals the number of clock cycles from the start cycle to the end cycle, counting both. When start and end fall in the same cycle, the count is 1.
- R4: The beat count (TX at 0x10, RX at 0x14) equals the number of cycles inside that same window in which the direction's valid input is high.
- R5: Start and end markers have no effect while a direction is not armed. A second start marker during a measurement is ignored. Markers that arrive after done leave the counts unchanged.
- R6: Status at offset 0x04 has bit0 for TX done and bit1 for RX done. A done bit is set once the end marker has been seen, and it is cleared when that direction is armed again.
- R7: The TX and RX measurements are independent: activity on one direction never changes the other direction's counts or done bit.
- R8: A count that reaches 2^CNT_W-1 stays at that value instead of wrapping.
- R9: Writing control bit2 zeroes all counts and done bits and disarms both directions in one cycle. Clear takes priority over arm bits in the same write.
- R10: Re-arming a direction keeps its previous counts readable until a new start marker arrives. That start marker restarts the counts, beginning at 1 for the cycle count.
- R11: Read data appears on the cycle after the read request. Offsets other than the six listed read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| tx_sof | input | 1 | Transmit frame-start marker |
| tx_eof | input | 1 | Transmit frame-end marker |
| tx_vld | input | 1 | Transmit beat valid |
| rx_sof | input | 1 | Receive frame-start marker |
| rx_eof | input | 1 | Receive frame-end marker |
| rx_vld | input | 1 | Receive beat valid |

## Verification
The bench builds two copies of the block and feeds them the same stimulus. One copy uses the default 32-bit counters. The other uses `CNT_W` = 4, so frames of up to 30 cycles push its counts past 15 and exercise saturation in both the cycle and the beat counters. The 32-bit copy shows the exact lengths. Comparing the two copies against each other makes the clamp visible alongside ordinary counting.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  // Byte offsets of the register map.
  localparam int unsigned OFS_CTRL   = 32'h00;
  localparam int unsigned OFS_STAT   = 32'h04;
  localparam int unsigned OFS_TX_CYC = 32'h08;
  localparam int unsigned OFS_RX_CYC = 32'h0C;
  localparam int unsigned OFS_TX_BT  = 32'h10;
  localparam int unsigned OFS_RX_BT  = 32'h14;

  // Control bit positions.
  localparam int unsigned CB_ARM_TX = 0;
  localparam int unsigned CB_ARM_RX = 1;
  localparam int unsigned CB_CLR    = 2;

  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_RUN   = 2'd2,
    CH_DONE  = 2'd3
  } ch_state_e;

  // Add inc to v, clamping the result at lim.
  function automatic logic [31:0] sat_add(input logic [31:0] v,
                                          input logic [31:0] inc,
                                          input logic [31:0] lim);
    logic [32:0] s;
    s = {1'b0, v} + {1'b0, inc};
    if (s > {1'b0, lim}) return lim;
    return s[31:0];
  endfunction

  // Largest value a counter of width w can hold.
  function automatic logic [31:0] cnt_max(input int unsigned w);
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    return m[31:0];
  endfunction

endpackage

// File: rtl/sfm_chan.sv
module sfm_chan
  import sfm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             clr_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             vld_i,
  output logic             armed_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] beat_o
);

  localparam logic [31:0] LIM = cnt_max(CNT_W);

  ch_state_e        st_q;
  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] beat_q;

  // Named internal events, used by the assertions below.
  logic start_ev;
  logic run_ev;
  logic stop_ev;
  logic [CNT_W-1:0] cyc_inc;
  logic [CNT_W-1:0] beat_inc;

  assign start_ev = (st_q == CH_ARMED) && sof_i;
  assign run_ev   = (st_q == CH_RUN);
  assign stop_ev  = (start_ev || run_ev) && eof_i;
  assign cyc_inc  = CNT_W'(sat_add(32'(cyc_q), 32'd1, LIM));
  assign beat_inc = CNT_W'(sat_add(32'(beat_q), 32'(vld_i), LIM));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      st_q   <= CH_IDLE;
      cyc_q  <= '0;
      beat_q <= '0;
    end else begin
      unique case (st_q)
        CH_IDLE, CH_DONE: begin
          if (arm_i) st_q <= CH_ARMED;
        end
        CH_ARMED: begin
          if (sof_i) begin
            cyc_q  <= CNT_W'(1);
            beat_q <= CNT_W'(vld_i);
            st_q   <= eof_i ? CH_DONE : CH_RUN;
          end
        end
        CH_RUN: begin
          cyc_q  <= cyc_inc;
          beat_q <= beat_inc;
          if (eof_i) st_q <= CH_DONE;
        end
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  assign armed_o = (st_q == CH_ARMED) || (st_q == CH_RUN);
  assign done_o  = (st_q == CH_DONE);
  assign cyc_o   = cyc_q;
  assign beat_o  = beat_q;

  AST_BEATS_LE_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q <= cyc_q); // R4
  AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(eof_i)); // R6
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_IDLE && !clr_i) |=> $stable(cyc_q) && $stable(beat_q)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cyc_q == '0) && (beat_q == '0) && !done_o && !armed_o); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cyc_q) && !clr_i && st_q != CH_ARMED) |=> (&cyc_q)); // R8
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !clr_i) |=> (cyc_q == CNT_W'(1))); // R10

endmodule

// File: rtl/sfm_regs.sv
module sfm_regs
  import sfm_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_en,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic [NUM_CH-1:0]        arm_o,
  output logic                     clr_o,
  input  logic [NUM_CH-1:0]        armed_i,
  input  logic [NUM_CH-1:0]        done_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cyc_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] beat_i
);

  logic wr_ctrl;
  logic rd_ev;
  logic mapped;
  logic [31:0] rd_nxt;

  assign wr_ctrl = reg_en && reg_we && (32'(reg_addr) == OFS_CTRL);
  assign rd_ev   = reg_en && !reg_we;
  assign clr_o   = wr_ctrl && reg_wdata[CB_CLR];
  assign arm_o[0] = wr_ctrl && !reg_wdata[CB_CLR] && reg_wdata[CB_ARM_TX];
  assign arm_o[1] = wr_ctrl && !reg_wdata[CB_CLR] && reg_wdata[CB_ARM_RX];

  always_comb begin
    rd_nxt = '0;
    mapped = 1'b1;
    unique case (32'(reg_addr))
      OFS_CTRL:   rd_nxt = 32'(armed_i);
      OFS_STAT:   rd_nxt = 32'(done_i);
      OFS_TX_CYC: rd_nxt = 32'(cyc_i[0]);
      OFS_RX_CYC: rd_nxt = 32'(cyc_i[1]);
      OFS_TX_BT:  rd_nxt = 32'(beat_i[0]);
      OFS_RX_BT:  rd_nxt = 32'(beat_i[1]);
      default:    mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     reg_rdata <= '0;
    else if (rd_ev) reg_rdata <= rd_nxt;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !mapped) |=> (reg_rdata == '0)); // R11
  AST_CLEAR_BEATS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> (arm_o == '0)); // R9

endmodule

// File: rtl/sfm_top.sv
module sfm_top
  import sfm_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_sof,
  input  logic              tx_eof,
  input  logic              tx_vld,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_vld
);

  logic [NUM_CH-1:0] sof_v, eof_v, vld_v;
  logic [NUM_CH-1:0] arm_v, armed_v, done_v;
  logic [NUM_CH-1:0][CNT_W-1:0] cyc_v, beat_v;
  logic clr;

  assign sof_v = {rx_sof, tx_sof};
  assign eof_v = {rx_eof, tx_eof};
  assign vld_v = {rx_vld, tx_vld};

  sfm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .arm_o(arm_v), .clr_o(clr),
    .armed_i(armed_v), .done_i(done_v), .cyc_i(cyc_v), .beat_i(beat_v)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sfm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .arm_i(arm_v[c]), .clr_i(clr),
      .sof_i(sof_v[c]), .eof_i(eof_v[c]), .vld_i(vld_v[c]),
      .armed_o(armed_v[c]), .done_o(done_v[c]),
      .cyc_o(cyc_v[c]), .beat_o(beat_v[c])
    );
  end

  // A direction that is neither armed nor finished sees no count movement.
  AST_CH_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_v[1] && !clr) |=> $stable(cyc_v[1])); // R7

endmodule

// File: tb/tb_sfm_top.sv
module tb_sfm_top;

  localparam int CLK_PER = 10;
  localparam int SW      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 0, reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic tx_sof = 0, tx_eof = 0, tx_vld = 0;
  logic rx_sof = 0, rx_eof = 0, rx_vld = 0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  sfm_top #(.ADDR_W(5), .CNT_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_a),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_vld(tx_vld),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_vld(rx_vld));

  sfm_top #(.ADDR_W(5), .CNT_W(SW)) dut_sat (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_b),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_vld(tx_vld),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_vld(rx_vld));

  // Clamp a true count to what a w-bit saturating counter shows.
  function automatic int unsigned clampw(input int unsigned v, input int w);
    int unsigned m;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    return (v > m) ? m : v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  // Read one offset from both copies and check against the expected raw count.
  task automatic rd_chk(input string tag, input logic [4:0] a,
                        input int unsigned exp_raw, input bit is_count);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_en = 0;
    chk({tag, " w32"}, rd_a, exp_raw);
    chk({tag, " w4"}, rd_b, is_count ? clampw(exp_raw, SW) : exp_raw);
  endtask

  task automatic frame(input int ch, input int lead, input int len,
                       input bit extra_sof, output int unsigned beats);
    beats = 0;
    repeat (lead) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      logic v;
      @(negedge clk);
      v = 1'($urandom % 2);
      if (v) beats++;
      if (ch == 0) begin
        tx_sof = (i == 0) || (extra_sof && i == len/2); tx_eof = (i == len-1); tx_vld = v;
      end else begin
        rx_sof = (i == 0) || (extra_sof && i == len/2); rx_eof = (i == len-1); rx_vld = v;
      end
    end
    @(negedge clk);
    if (ch == 0) begin tx_sof = 0; tx_eof = 0; tx_vld = 0; end
    else begin rx_sof = 0; rx_eof = 0; rx_vld = 0; end
  endtask

  task automatic check_counts(input string tag, input int unsigned tc, input int unsigned tb,
                              input int unsigned rc, input int unsigned rb);
    rd_chk({tag, " R3 tx cyc"}, 5'h08, tc, 1);
    rd_chk({tag, " R3 rx cyc"}, 5'h0C, rc, 1);
    rd_chk({tag, " R4 tx beat"}, 5'h10, tb, 1);
    rd_chk({tag, " R4 rx beat"}, 5'h14, rb, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned tb_, rb_, tc_, rc_, b0;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values
    rd_chk("R1 ctrl", 5'h00, 0, 0);
    rd_chk("R1 stat", 5'h04, 0, 0);
    check_counts("R1", 0, 0, 0, 0);
    // R11: unmapped offsets
    rd_chk("R11 unmapped 18", 5'h18, 0, 0);
    rd_chk("R11 unmapped 1C", 5'h1C, 0, 0);

    // R5: markers ignored when not armed
    frame(0, 0, 5, 0, b0);
    frame(1, 1, 3, 0, b0);
    check_counts("R5 unarmed", 0, 0, 0, 0);
    rd_chk("R5 stat unarmed", 5'h04, 0, 0);

    // R2: arm TX only
    wr(5'h00, 32'h1);
    rd_chk("R2 ctrl tx armed", 5'h00, 1, 0);
    // R3: start and end in one cycle
    frame(0, 2, 1, 0, tb_);
    rd_chk("R6 stat tx done", 5'h04, 1, 0);
    rd_chk("R2 ctrl after done", 5'h00, 0, 0);
    check_counts("R3 single R7", 1, tb_, 0, 0);

    // R5: extra start mid-frame ignored; R7 RX untouched
    wr(5'h00, 32'h1);
    frame(0, 0, 9, 1, tb_);
    check_counts("R5 extra sof", 9, tb_, 0, 0);
    // R5: markers after done ignored
    frame(0, 0, 4, 0, b0);
    check_counts("R5 after done", 9, tb_, 0, 0);

    // Random overlapping frames on both directions (R3 R4 R7 R8)
    for (int it = 0; it < 20; it++) begin
      int lt, lr, gt, gr;
      lt = 1 + int'($urandom % 30); lr = 1 + int'($urandom % 30);
      gt = int'($urandom % 4);      gr = int'($urandom % 4);
      wr(5'h00, 32'h3);
      fork
        frame(0, gt, lt, 0, tb_);
        frame(1, gr, lr, 0, rb_);
      join
      rd_chk("R6 stat both", 5'h04, 3, 0);
      check_counts("rand R8", lt, tb_, lr, rb_);
      tc_ = lt; rc_ = lr;
    end

    // R10: re-arm keeps stale counts, clears done
    wr(5'h00, 32'h2);
    rd_chk("R6 done cleared by rearm", 5'h04, 1, 0);
    check_counts("R10 stale", tc_, tb_, rc_, rb_);
    frame(1, 0, 20, 0, rb_);
    check_counts("R10 fresh R8", tc_, tb_, 20, rb_);

    // R9: clear wins over arm
    wr(5'h00, 32'h7);
    rd_chk("R9 ctrl", 5'h00, 0, 0);
    rd_chk("R9 stat", 5'h04, 0, 0);
    check_counts("R9 cleared", 0, 0, 0, 0);
    frame(0, 0, 3, 0, b0);
    check_counts("R9 disarmed", 0, 0, 0, 0);

    // R9: clear during measurement
    wr(5'h00, 32'h3);
    fork
      frame(0, 0, 12, 0, b0);
      begin repeat (4) @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = 5'h00; reg_wdata = 32'h4;
            @(negedge clk); reg_en = 0; reg_we = 0; end
    join
    check_counts("R9 mid clear", 0, 0, 0, 0);
    rd_chk("R9 mid clear stat", 5'h04, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule